// File: doc/BRIEF.md
# Dual-Channel Sine Synthesizer

This block is a numerically controlled sine source with two coherent outputs. A single 32-bit phase accumulator advances every clock by a signed tuning word plus a signed modulation term. Each of the two channels adds its own phase rotation word to the shared accumulator and uses the upper 12 bits of the sum to read a shared 4096-entry sine table. It then scales the table value by its own amplitude word and delivers a signed 14-bit sample every clock.

Output frequency is proportional to the tuning word, in steps of Fclk/2^32. The modulation input lets a neighbouring block apply frequency modulation or chirps without touching the base tuning word. A negative tuning word walks the table backwards. Two channels rotated by a quarter turn therefore form a quadrature pair whose rotation sense follows the sign of the tuning word. The table is computed at elaboration, so a phase change never needs a table reload.

Top module: `dds_dual_sine`

## Requirements
- R1: On every clock out of reset the accumulator grows by freq_word + mod_word, modulo 2^32. When that sum is zero, the phase and both outputs stay constant.
- R2: A channel reads the table at index k = bits [31:20] of (accumulator + its phase word), modulo 2^32. Entry k holds round-half-away(8191 * sin(2*pi*k/4096)) as a signed 14-bit value.
- R3: A channel output equals floor(entry * amp / 16384), where amp is the channel's unsigned 14-bit amplitude word. An amplitude of 0 gives 0, and 16383 is the unity setting.
- R4: The accumulator value, phase word and amplitude word present before a clock edge appear at the output after the third edge from it. A new freq_word loaded before an edge moves the accumulator at that edge, so the output first reflects it after the fourth edge.
- R5: wave_valid is low during reset and for the first two edges after reset is released. It is high from the third edge on.
- R6: A synchronous reset clears the accumulator to zero and drives both outputs to zero while wave_valid is low.
- R7: freq_word and mod_word are two's-complement, and a negative sum steps the table index downward.
- R8: Both channels share the one accumulator and the one table, so their only difference comes from their phase words. A phase word difference of M rotates by 360*M/2^32 degrees; for example, 2^30 is 90 degrees.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_word | input | 32 | Signed tuning word added every clock |
| mod_word | input | 32 | Signed modulation term added with the tuning word |
| phase_a | input | 32 | Phase rotation word, channel A |
| phase_b | input | 32 | Phase rotation word, channel B |
| amp_a | input | 14 | Unsigned amplitude word, channel A |
| amp_b | input | 14 | Unsigned amplitude word, channel B |
| wave_a | output | 14 | Signed sample, channel A |
| wave_b | output | 14 | Signed sample, channel B |
| wave_valid | output | 1 | High once the pipeline holds real samples |

## Verification
After reset is released with constant words, the sample seen after edge n belongs to accumulator value (n-3)*(freq_word+mod_word). Each table vector is therefore checked once its edge count n is known, and the reference for that n is computed in the bench. The amplitude and phase words are checked to be unchanged after two edges and changed after three. A tuning word change is checked to be unchanged after three edges and changed after four. wave_valid is sampled after the second and third edges. All sampling is done on the falling edge, half a cycle after the register it observes.

// File: rtl/dds_pkg.sv
package dds_pkg;
   localparam int  NCH        = 2;
   localparam int  PIPE_DEPTH = 3;
   localparam real TWO_PI     = 6.283185307179586;
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [ACC_W-1:0] freq_word,
   input  logic [ACC_W-1:0] mod_word,
   output logic [ACC_W-1:0] acc
);
   logic [ACC_W-1:0] step;
   logic [ACC_W-1:0] acc_q;

   assign step = freq_word + mod_word;

   always_ff @(posedge clk) begin
      if (rst) acc_q <= '0;
      else     acc_q <= acc_q + step;
   end

   assign acc = acc_q;

   AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
      ((freq_word + mod_word) == ACC_W'(0)) |=> $stable(acc)); // R1
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
   parameter int LUT_AW = 12,
   parameter int SAMP_W = 14,
   parameter int NRD    = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [NRD*LUT_AW-1:0]    rd_addr,
   output logic [NRD*SAMP_W-1:0]    rd_data
);
   localparam int DEPTH = 1 << LUT_AW;
   localparam int PEAK  = (1 << (SAMP_W - 1)) - 1;

   logic signed [SAMP_W-1:0] table_mem [DEPTH];

   initial begin
      real v;
      for (int k = 0; k < DEPTH; k++) begin
         v = real'(PEAK) * $sin(dds_pkg::TWO_PI * real'(k) / real'(DEPTH));
         table_mem[k] = SAMP_W'($rtoi((v >= 0.0) ? (v + 0.5) : (v - 0.5)));
      end
   end

   for (genvar c = 0; c < NRD; c++) begin : g_port
      logic signed [SAMP_W-1:0] q;
      always_ff @(posedge clk) begin
         if (rst) q <= '0;
         else     q <= table_mem[rd_addr[c*LUT_AW +: LUT_AW]];
      end
      assign rd_data[c*SAMP_W +: SAMP_W] = q;

      AST_LUT_RANGE: assert property (@(posedge clk) disable iff (rst)
         (q <= SAMP_W'(PEAK)) && (q >= -SAMP_W'(PEAK))); // R2
   end
endmodule

// File: rtl/dds_chan_path.sv
module dds_chan_path #(
   parameter int ACC_W  = 32,
   parameter int LUT_AW = 12,
   parameter int SAMP_W = 14,
   parameter int AMP_W  = 14
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [ACC_W-1:0]         acc,
   input  logic [ACC_W-1:0]         phase,
   input  logic [AMP_W-1:0]         amp,
   output logic [LUT_AW-1:0]        lut_addr,
   input  logic signed [SAMP_W-1:0] lut_data,
   output logic signed [SAMP_W-1:0] sample
);
   localparam int PROD_W = SAMP_W + AMP_W + 1;
   localparam int FRAC_W = ACC_W - LUT_AW;

   logic [ACC_W-1:0]         rotated;
   logic [FRAC_W-1:0]        unused_frac;
   logic [LUT_AW-1:0]        addr_q;
   logic [AMP_W-1:0]         amp_s1_q;
   logic [AMP_W-1:0]         amp_s2_q;
   logic signed [PROD_W-1:0] prod;
   logic [AMP_W:0]           unused_prod;
   logic signed [SAMP_W-1:0] sample_q;

   assign rotated     = acc + phase;
   assign unused_frac = rotated[FRAC_W-1:0];

   assign prod        = lut_data * $signed({1'b0, amp_s2_q});
   assign unused_prod = {prod[PROD_W-1], prod[AMP_W-1:0]};

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q   <= '0;
         amp_s1_q <= '0;
         amp_s2_q <= '0;
         sample_q <= '0;
      end else begin
         addr_q   <= rotated[ACC_W-1 -: LUT_AW];
         amp_s1_q <= amp;
         amp_s2_q <= amp_s1_q;
         sample_q <= prod[PROD_W-2 -: SAMP_W];
      end
   end

   assign lut_addr = addr_q;
   assign sample   = sample_q;

   AST_ZERO_AMP: assert property (@(posedge clk) disable iff (rst)
      (amp_s2_q == '0) |=> (sample == '0)); // R3
endmodule

// File: rtl/dds_dual_sine.sv
module dds_dual_sine #(
   parameter int ACC_W  = 32,
   parameter int LUT_AW = 12,
   parameter int SAMP_W = 14,
   parameter int AMP_W  = 14
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [ACC_W-1:0]         freq_word,
   input  logic [ACC_W-1:0]         mod_word,
   input  logic [ACC_W-1:0]         phase_a,
   input  logic [ACC_W-1:0]         phase_b,
   input  logic [AMP_W-1:0]         amp_a,
   input  logic [AMP_W-1:0]         amp_b,
   output logic signed [SAMP_W-1:0] wave_a,
   output logic signed [SAMP_W-1:0] wave_b,
   output logic                     wave_valid
);
   import dds_pkg::*;

   if (ACC_W <= LUT_AW) begin : g_chk_acc
      $error("accumulator must be wider than the table address");
   end
   if (SAMP_W < 2 || AMP_W < 1) begin : g_chk_samp
      $error("sample and amplitude widths too small");
   end
   if (LUT_AW > 16) begin : g_chk_depth
      $error("table depth beyond supported size");
   end

   logic [ACC_W-1:0]         acc;
   logic [ACC_W-1:0]         phase_arr [NCH];
   logic [AMP_W-1:0]         amp_arr   [NCH];
   logic signed [SAMP_W-1:0] wave_arr  [NCH];
   logic [NCH*LUT_AW-1:0]    rom_addr;
   logic [NCH*SAMP_W-1:0]    rom_data;
   logic [PIPE_DEPTH-1:0]    fill_q;

   assign phase_arr[0] = phase_a;
   assign phase_arr[1] = phase_b;
   assign amp_arr[0]   = amp_a;
   assign amp_arr[1]   = amp_b;

   dds_phase_acc #(.ACC_W(ACC_W)) acc_i (
      .clk       (clk),
      .rst       (rst),
      .freq_word (freq_word),
      .mod_word  (mod_word),
      .acc       (acc)
   );

   dds_sine_rom #(.LUT_AW(LUT_AW), .SAMP_W(SAMP_W), .NRD(NCH)) rom_i (
      .clk     (clk),
      .rst     (rst),
      .rd_addr (rom_addr),
      .rd_data (rom_data)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      dds_chan_path #(
         .ACC_W(ACC_W), .LUT_AW(LUT_AW), .SAMP_W(SAMP_W), .AMP_W(AMP_W)
      ) chan_i (
         .clk      (clk),
         .rst      (rst),
         .acc      (acc),
         .phase    (phase_arr[c]),
         .amp      (amp_arr[c]),
         .lut_addr (rom_addr[c*LUT_AW +: LUT_AW]),
         .lut_data ($signed(rom_data[c*SAMP_W +: SAMP_W])),
         .sample   (wave_arr[c])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) fill_q <= '0;
      else     fill_q <= {fill_q[PIPE_DEPTH-2:0], 1'b1};
   end

   assign wave_a     = wave_arr[0];
   assign wave_b     = wave_arr[1];
   assign wave_valid = fill_q[PIPE_DEPTH-1];

   AST_VALID_RESET: assert property (@(posedge clk)
      rst |=> !wave_valid); // R5
   AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
      wave_valid |=> wave_valid); // R5
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
      !wave_valid |-> (wave_a == '0 && wave_b == '0)); // R6
endmodule

// File: tb/dds_dual_sine_tb_top.sv
module dds_dual_sine_tb_top;
   localparam real TWO_PI = 6.283185307179586;

   typedef struct packed {
      logic [31:0] freq;
      logic [31:0] modw;
      logic [31:0] ph0;
      logic [31:0] ph1;
      logic [13:0] a0;
      logic [13:0] a1;
      logic [15:0] cyc;
   } vec_t;

   localparam int NVEC = 8;
   localparam vec_t VECS [NVEC] = '{
      '{32'h0010_0000, 32'h0000_0000, 32'h0000_0000, 32'h4000_0000, 14'd16383, 14'd16383, 16'd10},
      '{32'h0008_0000, 32'h0008_0000, 32'h1000_0000, 32'h9000_0000, 14'd12000, 14'd5000,  16'd40},
      '{32'h1234_5679, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001, 14'd8192,  14'd16383, 16'd77},
      '{32'h8000_0000, 32'h0000_0000, 32'h2000_0000, 32'h6000_0000, 14'd16383, 14'd16383, 16'd9},
      '{32'h0000_0001, 32'h0000_0000, 32'h4000_0000, 32'hC000_0000, 14'd16383, 14'd16383, 16'd50},
      '{32'h0300_0000, 32'hFF00_0000, 32'h0ABC_DEF0, 32'h5555_5555, 14'd0,     14'd1,     16'd25},
      '{32'hFFF0_0000, 32'h0000_0000, 32'h0000_0000, 32'h4000_0000, 14'd16383, 14'd16383, 16'd10},
      '{32'hDEAD_BEEF, 32'h0000_1111, 32'h0000_0007, 32'h8000_0000, 14'd3,     14'd16000, 16'd300}
   };

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic [31:0]        freq_word = '0;
   logic [31:0]        mod_word  = '0;
   logic [31:0]        phase_a   = '0;
   logic [31:0]        phase_b   = '0;
   logic [13:0]        amp_a     = '0;
   logic [13:0]        amp_b     = '0;
   logic signed [13:0] wave_a;
   logic signed [13:0] wave_b;
   logic               wave_valid;

   int  total = 0;
   int  bad   = 0;
   bit  done  = 1'b0;

   always #2 clk = ~clk;

   dds_dual_sine dut_i (
      .clk(clk), .rst(rst), .freq_word(freq_word), .mod_word(mod_word),
      .phase_a(phase_a), .phase_b(phase_b), .amp_a(amp_a), .amp_b(amp_b),
      .wave_a(wave_a), .wave_b(wave_b), .wave_valid(wave_valid)
   );

   function automatic int ref_sample(logic [31:0] acc, logic [31:0] ph, int amp);
      logic [31:0] s;
      int  idx;
      real v;
      int  e;
      s   = acc + ph;
      idx = int'(s[31:20]);
      v   = 8191.0 * $sin(TWO_PI * real'(idx) / 4096.0);
      e   = $rtoi((v >= 0.0) ? (v + 0.5) : (v - 0.5));
      return (e * amp) >>> 14;
   endfunction

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic load(vec_t v);
      freq_word = v.freq;
      mod_word  = v.modw;
      phase_a   = v.ph0;
      phase_b   = v.ph1;
      amp_a     = v.a0;
      amp_b     = v.a1;
   endtask

   task automatic restart();
      rst = 1'b1;
      step(2);
      rst = 1'b0;
   endtask

   initial begin
      vec_t        v;
      logic [31:0] acc_ref;
      @(negedge clk);

      // Reset state with live words on the inputs: R6, R5
      load(VECS[0]);
      step(2);
      chk("R6 reset wave_a", int'(wave_a), 0);
      chk("R6 reset wave_b", int'(wave_b), 0);
      chk("R5 valid in reset", int'(wave_valid), 0);

      // Pipeline fill: R5
      rst = 1'b0;
      step(2);
      chk("R5 valid after two edges", int'(wave_valid), 0);
      step(1);
      chk("R5 valid after three edges", int'(wave_valid), 1);

      // Vector table: R1 R2 R3 R8
      for (int i = 0; i < NVEC; i++) begin
         v = VECS[i];
         load(v);
         restart();
         step(int'(v.cyc));
         acc_ref = 32'(int'(v.cyc) - 3) * (v.freq + v.modw);
         chk($sformatf("vec%0d R1 R2 R3 wave_a", i), int'(wave_a),
             ref_sample(acc_ref, v.ph0, int'(v.a0)));
         chk($sformatf("vec%0d R2 R3 R8 wave_b", i), int'(wave_b),
             ref_sample(acc_ref, v.ph1, int'(v.a1)));
         chk($sformatf("vec%0d R5 valid", i), int'(wave_valid), 1);
      end

      // R7: negative tuning word walks backwards, quadrature pair
      freq_word = 32'hFFF0_0000; mod_word = '0;
      phase_a = '0; phase_b = 32'h4000_0000; amp_a = 14'd16383; amp_b = 14'd16383;
      restart();
      step(10);
      chk("R7 negative step wave_a", int'(wave_a), ref_sample(32'hFF90_0000, 32'h0, 16383));
      chk("R7 negative sign wave_a", int'(wave_a < 0), 1);
      chk("R7 R8 quadrature wave_b", int'(wave_b), ref_sample(32'hFF90_0000, 32'h4000_0000, 16383));

      // R1: tuning word cancelled by modulation holds the phase
      freq_word = 32'h0010_0000; mod_word = 32'hFFF0_0000;
      phase_a = 32'h2000_0000; phase_b = '0;
      restart();
      step(20);
      chk("R1 zero step wave_a", int'(wave_a), ref_sample(32'h0, 32'h2000_0000, 16383));
      step(7);
      chk("R1 zero step still", int'(wave_a), ref_sample(32'h0, 32'h2000_0000, 16383));

      // R4: amplitude word latency of three edges; R3 amplitude zero
      freq_word = '0; mod_word = '0; phase_a = 32'h4000_0000; amp_a = 14'd16383;
      restart();
      step(5);
      chk("R3 unity peak", int'(wave_a), 8190);
      amp_a = 14'd0;
      step(2);
      chk("R4 amp old after two edges", int'(wave_a), 8190);
      step(1);
      chk("R4 amp new after three edges", int'(wave_a), 0);

      // R4: phase word latency of three edges
      amp_a = 14'd16383;
      step(5);
      phase_a = 32'hC000_0000;
      step(2);
      chk("R4 phase old after two edges", int'(wave_a), 8190);
      step(1);
      chk("R4 phase new after three edges", int'(wave_a), -8191);

      // R4: tuning word takes effect at the next edge
      phase_a = '0;
      restart();
      step(5);
      chk("R4 idle at zero", int'(wave_a), 0);
      freq_word = 32'h0010_0000;
      step(3);
      chk("R4 freq old after three edges", int'(wave_a), 0);
      step(1);
      chk("R4 freq new after four edges", int'(wave_a), ref_sample(32'h0010_0000, 32'h0, 16383));

      // R6: mid-run reset clears outputs and restarts accumulator
      phase_a = 32'h4000_0000; phase_b = 32'h4000_0000;
      step(6);
      rst = 1'b1;
      step(1);
      chk("R6 mid-run reset wave_a", int'(wave_a), 0);
      chk("R6 mid-run reset wave_b", int'(wave_b), 0);
      chk("R5 mid-run reset valid", int'(wave_valid), 0);
      rst = 1'b0;
      step(3);
      chk("R6 accumulator restarts at zero", int'(wave_a), ref_sample(32'h0, 32'h4000_0000, 16383));

      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule